// File: doc/BRIEF.md
# Single-Bus CPU Control Sequencer

This block is the hardwired control unit of a small processor whose registers all share one internal bus. A step counter walks through a fixed list of register transfers. For each step the block asserts the enables that put one source on the bus and the enables that load the destinations. It also asserts the memory read request, the ALU add command and the choice between the constant and the Y register as the second ALU operand.

The first three steps fetch an instruction and are the same for every opcode. The program counter is incremented through the ALU and the Z register. Decode starts at step 4, using the opcode and register fields of the instruction register. LOAD moves a memory word into a general register. ADD adds two general registers through Y and Z. Memory is asynchronous. Any step that needs a memory result waits on a memory-function-complete handshake. During the wait the counter holds and no register is loaded.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the outputs are those of step 1. A reset taken in the middle of an instruction forces step 1 at once.
- R2: Step 1 drives PC on the bus (`bus_drv_o` bit 0). It asserts `mar_ld_o`, `mem_rd_o`, `const_sel_o`, `alu_add_o` and `z_ld_o`, and no other enable.
- R3: Step 2 drives Z (`bus_drv_o` bit 1). While `mfc_i` is low the step repeats with every load enable low. In the cycle where `mfc_i` is high, `pc_ld_o` is asserted and the counter advances.
- R4: Step 3 drives MDR (`bus_drv_o` bit 2) and asserts `ir_ld_o`. No other enable is asserted.
- R5: For opcode 2'b00 (LOAD), step 4 drives the IR address field (`bus_drv_o` bit 3) and asserts `mar_ld_o` and `mem_rd_o`.
- R6: For LOAD, step 5 drives MDR. It holds with no load enable while `mfc_i` is low. When `mfc_i` is high it asserts bit `rd_i` of `gpr_ld_o`, and the next cycle is step 1.
- R7: For opcode 2'b01 (ADD), step 4 drives register `rs_i` and loads Y. Step 5 drives register `rd_i`, asserts `alu_add_o` and `z_ld_o`, and leaves `const_sel_o` low. Step 6 drives Z and loads register `rd_i`, and the next cycle is step 1.
- R8: For opcodes 2'b10 and 2'b11, step 4 asserts no output at all, and the next cycle is step 1.
- R9: In every cycle at most one of the `bus_drv_o` and `gpr_drv_o` bits is high.
- R10: While a memory wait is unmet (step 2, or LOAD step 5, with `mfc_i` low), every register-load enable is low.
- R11: After the last step of an instruction the counter returns to step 1. A stalled step holds the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 2 | Opcode field of IR |
| rd_i | input | REG_W | Destination register field of IR |
| rs_i | input | REG_W | Source register field of IR |
| mfc_i | input | 1 | Memory function complete |
| bus_drv_o | output | 4 | Bus drive: bit0 PC, bit1 Z, bit2 MDR, bit3 IR address field |
| gpr_drv_o | output | N_REG | Bus drive per general register |
| gpr_ld_o | output | N_REG | Load enable per general register |
| pc_ld_o | output | 1 | Load PC from bus |
| mar_ld_o | output | 1 | Load MAR from bus |
| ir_ld_o | output | 1 | Load IR from bus |
| z_ld_o | output | 1 | Load Z from ALU |
| y_ld_o | output | 1 | Load Y from bus |
| mem_rd_o | output | 1 | Memory read request |
| alu_add_o | output | 1 | ALU performs add |
| const_sel_o | output | 1 | ALU second operand is the constant (else Y) |

## Verification
Some rules hold on every cycle whatever the opcode, and assertions check them on every clock. These are the single bus driver, the absence of loads during an unmet memory wait, the return to step 1 after a final step, the held counter during a stall, and the legal step range. Other behaviour depends on where the instruction is. The exact control word of each step, the decode split at step 4, wait stalls of different lengths, the idle step of an unknown opcode and a reset taken mid-instruction can only be shown by the bench's instruction sequences. The bench compares the complete output word against its expected word in every cycle.

// File: rtl/cpu_seq_pkg.sv
`timescale 1ns/1ps
package cpu_seq_pkg;
  localparam int unsigned STEP_W = 3;
  localparam int unsigned N_SRC  = 4;

  localparam logic [STEP_W-1:0] S1 = 3'd1;
  localparam logic [STEP_W-1:0] S2 = 3'd2;
  localparam logic [STEP_W-1:0] S3 = 3'd3;
  localparam logic [STEP_W-1:0] S4 = 3'd4;
  localparam logic [STEP_W-1:0] S5 = 3'd5;
  localparam logic [STEP_W-1:0] S6 = 3'd6;

  localparam logic [1:0] OP_LOAD = 2'b00;
  localparam logic [1:0] OP_ADD  = 2'b01;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_PC, SRC_Z, SRC_MDR, SRC_IRF
  } bus_src_e;
endpackage

// File: rtl/seq_onehot.sv
`timescale 1ns/1ps
module seq_onehot #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic         en_i,
  input  logic [W-1:0] idx_i,
  output logic [N-1:0] vec_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vec_o[i] = en_i && (idx_i == W'(i));
  end
endmodule

// File: rtl/seq_step_ctr.sv
`timescale 1ns/1ps
module seq_step_ctr
  import cpu_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              last_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= S1;
    else if (adv_i)  step_q <= last_i ? S1 : step_q + 1'b1;
  end

  assign step_o = step_q;

  // R11
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last_i) |=> (step_q == S1));
  // R11
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(step_q));
  // R1
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q >= S1) && (step_q <= S6));
endmodule

// File: rtl/seq_decode.sv
`timescale 1ns/1ps
module seq_decode
  import cpu_seq_pkg::*;
#(
  parameter int unsigned REG_W = 2
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [1:0]        opcode_i,
  input  logic [REG_W-1:0]  rd_i,
  input  logic [REG_W-1:0]  rs_i,
  input  logic              mfc_i,
  output bus_src_e          src_o,
  output logic              gdrv_en_o,
  output logic [REG_W-1:0]  gdrv_idx_o,
  output logic              gld_en_o,
  output logic [REG_W-1:0]  gld_idx_o,
  output logic              pc_ld_o,
  output logic              mar_ld_o,
  output logic              ir_ld_o,
  output logic              z_ld_o,
  output logic              y_ld_o,
  output logic              mem_rd_o,
  output logic              alu_add_o,
  output logic              const_sel_o,
  output logic              adv_o,
  output logic              last_o
);
  always_comb begin
    src_o       = SRC_NONE;
    gdrv_en_o   = 1'b0;
    gdrv_idx_o  = rs_i;
    gld_en_o    = 1'b0;
    gld_idx_o   = rd_i;
    pc_ld_o     = 1'b0;
    mar_ld_o    = 1'b0;
    ir_ld_o     = 1'b0;
    z_ld_o      = 1'b0;
    y_ld_o      = 1'b0;
    mem_rd_o    = 1'b0;
    alu_add_o   = 1'b0;
    const_sel_o = 1'b0;
    adv_o       = 1'b1;
    last_o      = 1'b0;
    unique case (step_i)
      S1: begin
        src_o = SRC_PC; mar_ld_o = 1'b1; mem_rd_o = 1'b1;
        const_sel_o = 1'b1; alu_add_o = 1'b1; z_ld_o = 1'b1;
      end
      S2: begin
        src_o = SRC_Z; pc_ld_o = mfc_i; adv_o = mfc_i;
      end
      S3: begin
        src_o = SRC_MDR; ir_ld_o = 1'b1;
      end
      S4: begin
        if (opcode_i == OP_LOAD) begin
          src_o = SRC_IRF; mar_ld_o = 1'b1; mem_rd_o = 1'b1;
        end else if (opcode_i == OP_ADD) begin
          gdrv_en_o = 1'b1; gdrv_idx_o = rs_i; y_ld_o = 1'b1;
        end else begin
          last_o = 1'b1;  // unknown opcode: idle step, back to fetch
        end
      end
      S5: begin
        if (opcode_i == OP_LOAD) begin
          src_o = SRC_MDR; gld_en_o = mfc_i; adv_o = mfc_i; last_o = 1'b1;
        end else if (opcode_i == OP_ADD) begin
          gdrv_en_o = 1'b1; gdrv_idx_o = rd_i;
          alu_add_o = 1'b1; z_ld_o = 1'b1;
        end else begin
          last_o = 1'b1;
        end
      end
      S6: begin
        if (opcode_i == OP_ADD) begin
          src_o = SRC_Z; gld_en_o = 1'b1;
        end
        last_o = 1'b1;
      end
      default: last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cpu_seq_ctrl.sv
`timescale 1ns/1ps
module cpu_seq_ctrl
  import cpu_seq_pkg::*;
#(
  parameter int unsigned N_REG = 4,
  localparam int unsigned REG_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        opcode_i,
  input  logic [REG_W-1:0]  rd_i,
  input  logic [REG_W-1:0]  rs_i,
  input  logic              mfc_i,
  output logic [N_SRC-1:0]  bus_drv_o,
  output logic [N_REG-1:0]  gpr_drv_o,
  output logic [N_REG-1:0]  gpr_ld_o,
  output logic              pc_ld_o,
  output logic              mar_ld_o,
  output logic              ir_ld_o,
  output logic              z_ld_o,
  output logic              y_ld_o,
  output logic              mem_rd_o,
  output logic              alu_add_o,
  output logic              const_sel_o
);
  logic [STEP_W-1:0] step;
  logic              adv, last;
  bus_src_e          src;
  logic              gdrv_en, gld_en, src_en;
  logic [REG_W-1:0]  gdrv_idx, gld_idx;
  logic [1:0]        src_idx;

  seq_step_ctr u_ctr (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(adv), .last_i(last), .step_o(step)
  );

  seq_decode #(.REG_W(REG_W)) u_dec (
    .step_i(step), .opcode_i(opcode_i), .rd_i(rd_i), .rs_i(rs_i), .mfc_i(mfc_i),
    .src_o(src), .gdrv_en_o(gdrv_en), .gdrv_idx_o(gdrv_idx),
    .gld_en_o(gld_en), .gld_idx_o(gld_idx),
    .pc_ld_o(pc_ld_o), .mar_ld_o(mar_ld_o), .ir_ld_o(ir_ld_o),
    .z_ld_o(z_ld_o), .y_ld_o(y_ld_o), .mem_rd_o(mem_rd_o),
    .alu_add_o(alu_add_o), .const_sel_o(const_sel_o),
    .adv_o(adv), .last_o(last)
  );

  always_comb begin
    src_en  = 1'b1;
    src_idx = 2'd0;
    case (src)
      SRC_PC:  src_idx = 2'd0;
      SRC_Z:   src_idx = 2'd1;
      SRC_MDR: src_idx = 2'd2;
      SRC_IRF: src_idx = 2'd3;
      default: src_en  = 1'b0;
    endcase
  end

  seq_onehot #(.N(N_SRC), .W(2)) u_bus_oh (
    .en_i(src_en), .idx_i(src_idx), .vec_o(bus_drv_o)
  );
  seq_onehot #(.N(N_REG), .W(REG_W)) u_gdrv_oh (
    .en_i(gdrv_en), .idx_i(gdrv_idx), .vec_o(gpr_drv_o)
  );
  seq_onehot #(.N(N_REG), .W(REG_W)) u_gld_oh (
    .en_i(gld_en), .idx_i(gld_idx), .vec_o(gpr_ld_o)
  );

  // R9
  bus_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_drv_o, gpr_drv_o}));
  // R10
  wait_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mfc_i && (step == S2 || (step == S5 && opcode_i == OP_LOAD)))
      |-> !(pc_ld_o || mar_ld_o || ir_ld_o || z_ld_o || y_ld_o || (|gpr_ld_o)));
endmodule

// File: tb/sim_cpu_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_seq_ctrl;
  localparam int N_REG = 4;
  localparam logic [3:0] B_PC = 4'b0001, B_Z = 4'b0010, B_MDR = 4'b0100, B_IR = 4'b1000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic [1:0] rd = 2'd0, rs = 2'd0;
  logic       mfc = 1'b0;
  logic [3:0] bus_drv, gpr_drv, gpr_ld;
  logic       pc_ld, mar_ld, ir_ld, z_ld, y_ld, mem_rd, alu_add, const_sel;

  int n_cmp = 0, n_bad = 0;
  logic [19:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cpu_seq_ctrl #(.N_REG(N_REG)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .rd_i(rd), .rs_i(rs),
    .mfc_i(mfc), .bus_drv_o(bus_drv), .gpr_drv_o(gpr_drv), .gpr_ld_o(gpr_ld),
    .pc_ld_o(pc_ld), .mar_ld_o(mar_ld), .ir_ld_o(ir_ld), .z_ld_o(z_ld),
    .y_ld_o(y_ld), .mem_rd_o(mem_rd), .alu_add_o(alu_add), .const_sel_o(const_sel)
  );

  // word: {bus[3:0], gdrv[3:0], gld[3:0], pc, mar, ir, z, y, rd, add, const}
  function automatic logic [19:0] ew(logic [3:0] b, logic [3:0] gd, logic [3:0] gl,
                                     logic pc, logic mar, logic ir, logic z, logic y,
                                     logic mr, logic ad, logic cs);
    return {b, gd, gl, pc, mar, ir, z, y, mr, ad, cs};
  endfunction

  function automatic logic [3:0] oh(logic [1:0] i);
    return 4'b0001 << i;
  endfunction

  // monitor
  always @(negedge clk) begin
    logic [19:0] act;
    act = {bus_drv, gpr_drv, gpr_ld, pc_ld, mar_ld, ir_ld, z_ld, y_ld, mem_rd, alu_add, const_sel};
    if (exp_q.size() > 0) begin
      logic [19:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (act !== e) begin
        n_bad++;
        $display("FAIL %s: control word actual %b expected %b", t, act, e);
      end
      n_cmp++;  // R9 single bus driver in every compared cycle
      if ($countones({bus_drv, gpr_drv}) > 1) begin
        n_bad++;
        $display("FAIL R9: bus drivers actual %b expected at most one set", {bus_drv, gpr_drv});
      end
    end
  end

  task automatic step(input logic [19:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
  endtask

  task automatic fetch(input int waits);
    mfc = 1'b0;
    step(ew(B_PC, 0, 0, 0, 1, 0, 1, 0, 1, 1, 1), "R2");
    for (int i = 0; i < waits; i++) step(ew(B_Z, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R3");
    mfc = 1'b1;
    step(ew(B_Z, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0), "R3");
    mfc = 1'b0;
    step(ew(B_MDR, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0), "R4");
  endtask

  task automatic do_load(input logic [1:0] d, input int w1, input int w2);
    opcode = 2'b00; rd = d; rs = ~d;
    fetch(w1);
    step(ew(B_IR, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0), "R5");
    for (int i = 0; i < w2; i++) step(ew(B_MDR, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R6");
    mfc = 1'b1;
    step(ew(B_MDR, 0, oh(d), 0, 0, 0, 0, 0, 0, 0, 0), "R6");
    mfc = 1'b0;
  endtask

  task automatic do_add(input logic [1:0] d, input logic [1:0] s, input int w1);
    opcode = 2'b01; rd = d; rs = s;
    fetch(w1);
    step(ew(0, oh(s), 0, 0, 0, 0, 0, 1, 0, 0, 0), "R7");
    step(ew(0, oh(d), 0, 0, 0, 0, 1, 0, 0, 1, 0), "R7");
    step(ew(B_Z, 0, oh(d), 0, 0, 0, 0, 0, 0, 0, 0), "R7");
  endtask

  task automatic do_nop(input logic [1:0] op);
    opcode = op; rd = 2'd3; rs = 2'd2;
    fetch(0);
    step(ew(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R8");
  endtask

  initial begin
    @(posedge clk); #1;
    // R1: outputs of step 1 while held in reset
    step(ew(B_PC, 0, 0, 0, 1, 0, 1, 0, 1, 1, 1), "R1");
    rst_ni = 1'b1;
    do_load(2'd2, 0, 2);
    do_add(2'd1, 2'd3, 1);
    do_nop(2'b10);           // R8 next cycle must be step 1 (R11)
    do_load(2'd3, 3, 0);
    do_nop(2'b11);
    do_add(2'd0, 2'd0, 0);
    do_load(2'd0, 1, 1);
    // R1: reset in the middle of an ADD
    opcode = 2'b01; rd = 2'd2; rs = 2'd1;
    fetch(0);
    step(ew(0, oh(2'd1), 0, 0, 0, 0, 0, 1, 0, 0, 0), "R7");
    rst_ni = 1'b0;
    step(ew(B_PC, 0, 0, 0, 1, 0, 1, 0, 1, 1, 1), "R1");
    rst_ni = 1'b1;
    do_add(2'd3, 2'd2, 2);
    do_load(2'd1, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run actual still busy expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule